// File: doc/BRIEF.md
# SPI Slave with Buffered Transmit and Receive Words

This block is the target side of a four-wire serial link. An external master drives the serial clock, an active-low select and serial data in; the block answers on serial data out. Every input is brought into the system clock domain through two-flop synchronisers, and serial clock edges are detected there. The system clock must therefore run at least four times faster than the serial clock. Words are 16 bits wide. The link uses clock mode 0 with the most significant bit first: data in is sampled on the rising serial clock edge, and data out changes after the falling edge.

Software sees one transmit holding word and one receive holding word. Each word has a status flag, and a sticky overrun flag covers the receive side. A word leaves the transmit holding register when the shifter takes it: either when select is asserted or right after the last bit of a word. When no new word has been written by then, the shifter is not reloaded, so the next word returns the bits that were just received. Raising select part way through a word throws the partial word away. Writing the transmit word never starts a transfer, and receive-only use needs no writes at all.

Top module: `spi_slave_buf`

## Requirements
- R1: While select (`ss_ni`) is high, `sdo_o` is 0, and serial clock and data activity neither completes a receive word nor consumes the buffered transmit word.
- R2: Mode 0, MSB first. Before the first rising serial clock edge of a word, `sdo_o` presents bit 15 of the outgoing word. It then changes only after a falling serial clock edge or the assertion of select.
- R3: After 16 rising serial clock edges with select low, `rx_data_o` holds the 16 sampled bits, the first sampled bit at bit 15, and `rx_full_o` is 1.
- R4: A one-cycle `rx_re_i` pulse clears `rx_full_o`.
- R5: `tx_we_i` loads `tx_data_i` and clears `tx_empty_o`. `tx_empty_o` returns to 1 when the word moves into the shifter, which happens at select assertion or after the 16th falling edge.
- R6: When the transmit word is empty at a word boundary, the next word sends out the word just received. When select asserts with the transmit word empty, the first word sent is all zeros.
- R7: Raising select mid-word discards the partial word and does not set `rx_full_o`. The next word after select falls again is received and sent aligned from bit 15.
- R8: A transmit write with no serial clock edges under select leaves `rx_full_o` at 0 and the word still buffered. Receive works without any transmit write.
- R9: If a word completes while `rx_full_o` is 1, `rx_data_o` takes the new word and `rx_ovr_o` sets. `rx_ovr_o` stays set through reads until an `ovr_clr_i` pulse clears it.
- R10: After reset, `tx_empty_o` is 1, and `rx_full_o`, `rx_ovr_o` and `sdo_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from master |
| ss_ni | input | 1 | Select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| tx_data_i | input | 16 | Transmit word to buffer |
| tx_we_i | input | 1 | Transmit word write strobe |
| tx_empty_o | output | 1 | Transmit word buffer empty |
| rx_data_o | output | 16 | Last received word |
| rx_re_i | input | 1 | Receive word read strobe |
| rx_full_o | output | 1 | Receive word waiting |
| rx_ovr_o | output | 1 | Sticky receive overrun |
| ovr_clr_i | input | 1 | Clear overrun flag |

## Verification
The assertions check several properties on every cycle. The output bit stays still between falling edges. The receive flag rises only on a completed word and never while select is idle. A read clears the receive flag, and a write fills the transmit buffer. The overrun flag is sticky, has a clear, and has a cause. The bench scenarios are needed for the data itself. Only they show MSB-first ordering of received and sent words, the echo of the previous word on underrun, the zero word after select with an empty buffer, and correct realignment after a partial word is discarded.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  typedef struct packed {
    logic act;
    logic start;
    logic rise;
    logic fall;
  } sck_evt_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/spi_edge.sv
module spi_edge
  import spi_slave_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_s_i,
  input  logic     ss_ns_i,
  output sck_evt_t evt_o
);
  logic sclk_q, ss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      ss_q   <= ss_ns_i;
    end
  end

  always_comb begin
    evt_o.act   = ~ss_ns_i;
    evt_o.start = ss_q & ~ss_ns_i;
    evt_o.rise  = ~ss_ns_i & sclk_s_i & ~sclk_q;
    evt_o.fall  = ~ss_ns_i & ~sclk_s_i & sclk_q;
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift
  import spi_slave_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  sck_evt_t     evt_i,
  input  logic         sdi_s_i,
  input  logic [W-1:0] tx_word_i,
  input  logic         tx_avail_i,
  output logic         tx_take_o,
  output logic         done_o,
  output logic [W-1:0] rx_word_o,
  output logic         sdo_bit_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          pend, rx_bit;
  logic          boundary;

  // falling edge that closes a full word
  assign boundary  = evt_i.fall & pend & (cnt == '0);
  assign tx_take_o = tx_avail_i & (evt_i.start | boundary);
  assign done_o    = evt_i.rise & (cnt == LAST);
  assign rx_word_o = {sh[W-2:0], sdi_s_i};
  assign sdo_bit_o = sh[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh     <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
      rx_bit <= 1'b0;
    end else if (!evt_i.act) begin
      sh   <= '0;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (evt_i.rise) begin
        rx_bit <= sdi_s_i;
        cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
        pend   <= 1'b1;
      end
      if (tx_take_o) begin
        sh <= tx_word_i;
      end else if (evt_i.fall && pend) begin
        sh <= {sh[W-2:0], rx_bit};
      end
      if (evt_i.fall) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_bufs.sv
module spi_bufs #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_we_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_take_i,
  input  logic         done_i,
  input  logic [W-1:0] rx_word_i,
  input  logic         rx_re_i,
  input  logic         ovr_clr_i,
  output logic [W-1:0] tx_buf_o,
  output logic         tx_full_o,
  output logic [W-1:0] rx_buf_o,
  output logic         rx_full_o,
  output logic         ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_o  <= '0;
      tx_full_o <= 1'b0;
    end else if (tx_we_i) begin
      tx_buf_o  <= tx_data_i;
      tx_full_o <= 1'b1;
    end else if (tx_take_i) begin
      tx_full_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_o  <= '0;
      rx_full_o <= 1'b0;
      ovr_o     <= 1'b0;
    end else if (done_i) begin
      rx_buf_o  <= rx_word_i;
      rx_full_o <= 1'b1;
      // a read in the same cycle takes the old word
      if (rx_full_o && !rx_re_i) ovr_o <= 1'b1;
      else if (ovr_clr_i)        ovr_o <= 1'b0;
    end else begin
      if (rx_re_i)   rx_full_o <= 1'b0;
      if (ovr_clr_i) ovr_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf
  import spi_slave_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              ss_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_we_i,
  output logic              tx_empty_o,
  output logic [WORD_W-1:0] rx_data_o,
  input  logic              rx_re_i,
  output logic              rx_full_o,
  output logic              rx_ovr_o,
  input  logic              ovr_clr_i
);
  logic [2:0]        pins_s;
  sck_evt_t          evt;
  logic              ss_act, sck_fall, sck_start, word_done;
  logic              tx_take, tx_full, sdo_bit;
  logic [WORD_W-1:0] tx_buf, rx_word;

  spi_sync #(.W(3), .RST_VAL(3'b010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, ss_ni, sdi_i}),
    .q_o   (pins_s)
  );

  spi_edge i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(pins_s[2]),
    .ss_ns_i (pins_s[1]),
    .evt_o   (evt)
  );

  spi_shift #(.W(WORD_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .sdi_s_i   (pins_s[0]),
    .tx_word_i (tx_buf),
    .tx_avail_i(tx_full),
    .tx_take_o (tx_take),
    .done_o    (word_done),
    .rx_word_o (rx_word),
    .sdo_bit_o (sdo_bit)
  );

  spi_bufs #(.W(WORD_W)) i_bufs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_we_i  (tx_we_i),
    .tx_data_i(tx_data_i),
    .tx_take_i(tx_take),
    .done_i   (word_done),
    .rx_word_i(rx_word),
    .rx_re_i  (rx_re_i),
    .ovr_clr_i(ovr_clr_i),
    .tx_buf_o (tx_buf),
    .tx_full_o(tx_full),
    .rx_buf_o (rx_data_o),
    .rx_full_o(rx_full_o),
    .ovr_o    (rx_ovr_o)
  );

  assign ss_act     = evt.act;
  assign sck_fall   = evt.fall;
  assign sck_start  = evt.start;
  assign sdo_o      = ss_act & sdo_bit;
  assign tx_empty_o = ~tx_full;
endmodule

// File: rtl/spi_slave_chk.sv
module spi_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic act,
  input logic fall,
  input logic start,
  input logic sdo_o,
  input logic word_done,
  input logic rx_re_i,
  input logic rx_full_o,
  input logic tx_we_i,
  input logic tx_empty_o,
  input logic rx_ovr_o,
  input logic ovr_clr_i
);
  p_rx_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act && !rx_full_o) |=> !rx_full_o);

  p_sdo_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && $past(act) && !$past(fall) && !$past(start)) |-> $stable(sdo_o));

  p_rx_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> $past(word_done));

  p_read_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_re_i && !word_done) |=> !rx_full_o);

  p_write_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_i |=> !tx_empty_o);

  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovr_o && !ovr_clr_i) |=> rx_ovr_o);

  p_ovr_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_clr_i && !(word_done && rx_full_o && !rx_re_i)) |=> !rx_ovr_o);

  p_ovr_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovr_o) |-> $past(word_done && rx_full_o));
endmodule

bind spi_slave_buf spi_slave_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .act       (ss_act),
  .fall      (sck_fall),
  .start     (sck_start),
  .sdo_o     (sdo_o),
  .word_done (word_done),
  .rx_re_i   (rx_re_i),
  .rx_full_o (rx_full_o),
  .tx_we_i   (tx_we_i),
  .tx_empty_o(tx_empty_o),
  .rx_ovr_o  (rx_ovr_o),
  .ovr_clr_i (ovr_clr_i)
);

// File: tb/test_spi_slave_buf.sv
module test_spi_slave_buf;
  localparam int HALF = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sclk = 1'b0, ss_n = 1'b1, sdi = 1'b0;
  logic        sdo, tx_we = 1'b0, rx_re = 1'b0, ovr_clr = 1'b0;
  logic [15:0] tx_data = '0, rx_data;
  logic        tx_empty, rx_full, rx_ovr;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spi_slave_buf i_spi_slave_buf (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .ss_ni(ss_n), .sdi_i(sdi),
    .sdo_o(sdo), .tx_data_i(tx_data), .tx_we_i(tx_we), .tx_empty_o(tx_empty),
    .rx_data_o(rx_data), .rx_re_i(rx_re), .rx_full_o(rx_full),
    .rx_ovr_o(rx_ovr), .ovr_clr_i(ovr_clr)
  );

  function automatic logic [15:0] mval(int k);
    return 16'(k * 32'h2F1D + 32'h0135);
  endfunction
  function automatic logic [15:0] tval(int k);
    return ~mval(k) ^ 16'(k * 32'h0101);
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [15:0] d);
    tx_data = d; tx_we = 1'b1; tick(1); tx_we = 1'b0;
  endtask

  task automatic read_rx();
    rx_re = 1'b1; tick(1); rx_re = 1'b0; tick(1);
  endtask

  task automatic sel(input logic v);
    ss_n = v; tick(HALF);
  endtask

  task automatic word(input logic [15:0] mosi, input int nbits, input bit wr,
                      input logic [15:0] wd, output logic [15:0] miso);
    miso = '0;
    for (int i = 0; i < nbits; i++) begin
      sdi = mosi[15-i];
      tick(HALF);
      miso[15-i] = sdo;
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
      if (wr && i == 4) write_tx(wd);
    end
    tick(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] got;
    tick(3);
    // R10 reset state
    chk("R10 tx_empty", {15'b0, tx_empty}, 16'h1);
    chk("R10 rx_full", {15'b0, rx_full}, 16'h0);
    chk("R10 rx_ovr", {15'b0, rx_ovr}, 16'h0);
    chk("R10 sdo", {15'b0, sdo}, 16'h0);
    rst_n = 1'b1;
    tick(2);

    // R8/R1: write with select high, clock toggles ignored
    write_tx(tval(0));
    chk("R8 write no transfer", {15'b0, rx_full}, 16'h0);
    word(16'hFFFF, 16, 1'b0, '0, got);
    chk("R1 sdo idle", got, 16'h0000);
    chk("R1 rx_full idle", {15'b0, rx_full}, 16'h0);
    chk("R1 tx kept", {15'b0, tx_empty}, 16'h0);

    // sweep of buffered words: R2 R3 R4 R5
    sel(1'b0);
    chk("R5 taken at select", {15'b0, tx_empty}, 16'h1);
    for (int k = 0; k < 6; k++) begin
      word(mval(k), 16, k < 5, tval(k + 1), got);
      chk("R2 miso word", got, tval(k));
      chk("R3 rx_full", {15'b0, rx_full}, 16'h1);
      chk("R3 rx_data", rx_data, mval(k));
      if (k < 5) chk("R5 taken at boundary", {15'b0, tx_empty}, 16'h1);
      read_rx();
      chk("R4 read clears", {15'b0, rx_full}, 16'h0);
    end
    // R6 underrun echo
    for (int k = 6; k < 8; k++) begin
      word(mval(k), 16, 1'b0, '0, got);
      chk("R6 echo previous", got, mval(k - 1));
      chk("R3 rx_data", rx_data, mval(k));
      read_rx();
    end
    sel(1'b1);
    chk("R1 sdo idle after", {15'b0, sdo}, 16'h0);

    // R7 partial word discarded
    sel(1'b0);
    word(16'hFFFF, 7, 1'b0, '0, got);
    sel(1'b1);
    chk("R7 no rx_full", {15'b0, rx_full}, 16'h0);
    write_tx(16'h3C3C);
    chk("R5 write clears empty", {15'b0, tx_empty}, 16'h0);
    sel(1'b0);
    word(16'h8001, 16, 1'b0, '0, got);
    chk("R7 miso aligned", got, 16'h3C3C);
    chk("R7 rx aligned", rx_data, 16'h8001);
    read_rx();
    sel(1'b1);

    // R6 zeros with empty buffer, R8 receive only, R9 overrun
    sel(1'b0);
    word(16'h1111, 16, 1'b0, '0, got);
    chk("R6 zero word", got, 16'h0000);
    chk("R8 receive only", rx_data, 16'h1111);
    word(16'h2222, 16, 1'b0, '0, got);
    chk("R6 echo", got, 16'h1111);
    chk("R9 ovr set", {15'b0, rx_ovr}, 16'h1);
    chk("R9 overwrite", rx_data, 16'h2222);
    sel(1'b1);
    read_rx();
    chk("R9 ovr sticky", {15'b0, rx_ovr}, 16'h1);
    ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0; tick(1);
    chk("R9 ovr cleared", {15'b0, rx_ovr}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule